// File: doc/BRIEF.md
# Five-Stage Pipelined 32-bit Integer Core

This block is an in-order 32-bit integer core. Instructions pass through five stages: fetch, decode, execute, memory access and writeback. A register of clocked flops with its own enable and synchronous clear separates each pair of stages. The core reads instruction words from an external instruction memory. It drives address, store data and a write strobe to an external data memory, and takes load data back in the same cycle. Both memories answer combinationally, so neither interface has back-pressure. A stall is the only way to hold an instruction in place, and it comes from the hazard controller.

The core contains no hazard logic of its own. It exports the register numbers and write-control bits of its decode, execute, memory and writeback stages, and whether the decode-stage instruction is a branch or is redirecting fetch. A separate hazard controller returns per-stage stall, flush and forwarding-select signals. Branches are predicted not taken and are resolved in decode. When a branch is taken, or a jump is decoded, the sequentially fetched word is cleared before it can execute. The cost is one lost fetch slot.

The supported instruction set is register-register add, sub, and, or and set-less-than, plus add-immediate, load word, store word, branch-if-equal and jump.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0.
- R2: After reset, `imem_addr` advances by 4 on every clock in which `stall_f` is low and decode is not redirecting. While `stall_f` is high, `imem_addr` holds.
- R3: Encoding fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], immediate [15:0] and function [5:0]. Opcode 000000 selects a register-register operation by function code: 100000 add, 100010 sub, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0). Opcode 001000 adds the sign-extended immediate to rs and writes rt. Opcode 100011 loads the word at rs+imm into rt. Opcode 101011 stores rt to rs+imm. Any other opcode or function code changes no register and no memory.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: A decode read of a register that is written back in the same cycle returns the new value.
- R6: The execute operand selects `fwd_a_e` and `fwd_b_e` choose 00 for the register-file value, 01 for the writeback result and 10 for the memory-stage ALU result. `fwd_a_d` and `fwd_b_d` set to 1 make the branch comparator use the memory-stage ALU result.
- R7: Opcode 000100 compares rs with rt in decode. If they are equal, `redirect_d` rises and the next fetch address is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise fetch continues sequentially.
- R8: Opcode 000010 always redirects. The next fetch address is PC+4 bits [31:28] joined with instruction bits [25:0] and then 2'b00.
- R9: `flush_d` turns the fetched word into a no-op. `flush_e` puts a bubble into execute with its register-write and memory-write controls cleared. Neither has any architectural effect.
- R10: `stall_d` holds the decode-stage instruction unchanged.
- R11: The self-check program stores 7 to data address 84. No instruction skipped by a taken branch or by a jump makes any store or register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch byte address (PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address from the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| hz_rs_d | output | 5 | Decode-stage rs field |
| hz_rt_d | output | 5 | Decode-stage rt field |
| hz_rs_e | output | 5 | Execute-stage rs |
| hz_rt_e | output | 5 | Execute-stage rt |
| hz_wreg_e | output | 5 | Execute-stage destination register |
| hz_wreg_m | output | 5 | Memory-stage destination register |
| hz_wreg_w | output | 5 | Writeback-stage destination register |
| hz_regw_e | output | 1 | Execute-stage instruction writes a register |
| hz_regw_m | output | 1 | Memory-stage instruction writes a register |
| hz_regw_w | output | 1 | Writeback-stage instruction writes a register |
| hz_load_e | output | 1 | Execute-stage instruction is a load |
| hz_load_m | output | 1 | Memory-stage instruction is a load |
| hz_branch_d | output | 1 | Decode-stage instruction is a branch |
| redirect_d | output | 1 | Decode is steering fetch (taken branch or jump) |
| stall_f | input | 1 | Hold the PC |
| stall_d | input | 1 | Hold the decode-stage register |
| flush_d | input | 1 | Clear the decode-stage register |
| flush_e | input | 1 | Clear the execute-stage register |
| fwd_a_d | input | 1 | Branch comparator rs source |
| fwd_b_d | input | 1 | Branch comparator rt source |
| fwd_a_e | input | 2 | Execute operand A source |
| fwd_b_e | input | 2 | Execute operand B and store data source |

## Verification
Most internal faults in this core first appear on the data-memory port. A wrong forward or a stale register read gives a wrong `dmem_wdata` or `dmem_addr` on the next dependent store, a few cycles after the fault. A wrongly steered PC shows on `imem_addr` in the very next cycle. A missed flush shows up as an extra store, or as a changed register that corrupts a later store. Every store is therefore compared in order against the expected list, and any store not on that list is itself a failure.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_to_reg;
    logic    mem_write;
    logic    alu_src;
    logic    reg_dst;
    alu_op_e alu_op;
  } ctrl_t;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_ADDI = 6'b001000;
  localparam logic [5:0] OPC_JMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/pipe5_stage_reg.sv
module pipe5_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // clear wins over enable so a flush always leaves a bubble
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (en)    q <= d;
  end
endmodule

// File: rtl/pipe5_decoder.sv
module pipe5_decoder
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       is_branch,
  output logic       is_jump
);
  always_comb begin
    ctrl      = '0;
    ctrl.alu_op = ALU_ADD;
    is_branch = 1'b0;
    is_jump   = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        ctrl.reg_dst = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:   begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_OR;  end
          FN_SLT:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ctrl.reg_dst = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_src    = 1'b1;
      end
      OPC_STOR: begin
        ctrl.mem_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OPC_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OPC_BEQ: is_branch = 1'b1;
      OPC_JMP: is_jump   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter  int XW   = 32,
  parameter  int NREG = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [XW-1:0]        wdata,
  input  logic [1:0][AW-1:0]   raddr,
  output logic [1:0][XW-1:0]   rdata
);
  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // read ports with write-through bypass; index 0 is hardwired zero
  for (genvar gp = 0; gp < 2; gp++) begin : g_rd
    always_comb begin
      if (raddr[gp] == '0)                     rdata[gp] = '0;
      else if (we && (waddr == raddr[gp]))     rdata[gp] = wdata;
      else                                     rdata[gp] = regs[raddr[gp]];
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XW = 32
) (
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int XW   = XLEN,
  localparam int RW   = RIDX
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [XW-1:0] imem_addr,
  input  logic [XW-1:0] imem_rdata,
  output logic [XW-1:0] dmem_addr,
  output logic [XW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [XW-1:0] dmem_rdata,
  output logic [RW-1:0] hz_rs_d,
  output logic [RW-1:0] hz_rt_d,
  output logic [RW-1:0] hz_rs_e,
  output logic [RW-1:0] hz_rt_e,
  output logic [RW-1:0] hz_wreg_e,
  output logic [RW-1:0] hz_wreg_m,
  output logic [RW-1:0] hz_wreg_w,
  output logic          hz_regw_e,
  output logic          hz_regw_m,
  output logic          hz_regw_w,
  output logic          hz_load_e,
  output logic          hz_load_m,
  output logic          hz_branch_d,
  output logic          redirect_d,
  input  logic          stall_f,
  input  logic          stall_d,
  input  logic          flush_d,
  input  logic          flush_e,
  input  logic          fwd_a_d,
  input  logic          fwd_b_d,
  input  logic [1:0]    fwd_a_e,
  input  logic [1:0]    fwd_b_e
);
  typedef struct packed {
    logic [XW-1:0] instr;
    logic [XW-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    ctrl_t         c;
    logic [XW-1:0] rd1;
    logic [XW-1:0] rd2;
    logic [XW-1:0] simm;
    logic [RW-1:0] rs;
    logic [RW-1:0] rt;
    logic [RW-1:0] rd;
  } idex_t;

  typedef struct packed {
    logic          regw;
    logic          m2r;
    logic          memw;
    logic [XW-1:0] alu;
    logic [XW-1:0] wd;
    logic [RW-1:0] wreg;
  } exmem_t;

  typedef struct packed {
    logic          regw;
    logic          m2r;
    logic [XW-1:0] rdata;
    logic [XW-1:0] alu;
    logic [RW-1:0] wreg;
  } memwb_t;

  // ---------------- fetch ----------------
  logic [XW-1:0] pc_q, pc_next, pc4_f;
  assign pc4_f     = pc_q + XW'(4);
  assign imem_addr = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (!stall_f) pc_q <= pc_next;
  end

  ifid_t ifid_d, ifid_q;
  assign ifid_d.instr = imem_rdata;
  assign ifid_d.pc4   = pc4_f;

  pipe5_stage_reg #(.W($bits(ifid_t))) u_ifid (
    .clk(clk), .rst_n(rst_n), .en(!stall_d), .clr(flush_d),
    .d(ifid_d), .q(ifid_q)
  );

  // ---------------- decode ----------------
  logic [XW-1:0] instr_d, pc4_d, simm_d, rd1_d, rd2_d;
  logic [XW-1:0] cmp_a, cmp_b, br_tgt, jmp_tgt, result_w;
  logic [RW-1:0] rs_d, rt_d, rd_d;
  ctrl_t         ctrl_d;
  logic          branch_d, jump_d, taken_d;
  logic [1:0][RW-1:0] rf_raddr;
  logic [1:0][XW-1:0] rf_rdata;
  exmem_t        exmem_q;
  memwb_t        memwb_q;

  assign instr_d = ifid_q.instr;
  assign pc4_d   = ifid_q.pc4;
  assign rs_d    = instr_d[25:21];
  assign rt_d    = instr_d[20:16];
  assign rd_d    = instr_d[15:11];
  assign simm_d  = {{(XW-16){instr_d[15]}}, instr_d[15:0]};

  pipe5_decoder u_dec (
    .opcode(instr_d[31:26]), .funct(instr_d[5:0]),
    .ctrl(ctrl_d), .is_branch(branch_d), .is_jump(jump_d)
  );

  assign rf_raddr[0] = rs_d;
  assign rf_raddr[1] = rt_d;

  pipe5_regfile #(.XW(XW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(memwb_q.regw), .waddr(memwb_q.wreg), .wdata(result_w),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );
  assign rd1_d = rf_rdata[0];
  assign rd2_d = rf_rdata[1];

  assign cmp_a   = fwd_a_d ? exmem_q.alu : rd1_d;
  assign cmp_b   = fwd_b_d ? exmem_q.alu : rd2_d;
  assign taken_d = branch_d && (cmp_a == cmp_b);
  assign br_tgt  = pc4_d + {simm_d[XW-3:0], 2'b00};
  assign jmp_tgt = {pc4_d[XW-1:XW-4], instr_d[25:0], 2'b00};

  always_comb begin
    if (jump_d)       pc_next = jmp_tgt;
    else if (taken_d) pc_next = br_tgt;
    else              pc_next = pc4_f;
  end

  assign redirect_d  = taken_d | jump_d;
  assign hz_branch_d = branch_d;
  assign hz_rs_d     = rs_d;
  assign hz_rt_d     = rt_d;

  idex_t idex_d, idex_q;
  assign idex_d.c    = ctrl_d;
  assign idex_d.rd1  = rd1_d;
  assign idex_d.rd2  = rd2_d;
  assign idex_d.simm = simm_d;
  assign idex_d.rs   = rs_d;
  assign idex_d.rt   = rt_d;
  assign idex_d.rd   = rd_d;

  pipe5_stage_reg #(.W($bits(idex_t))) u_idex (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(flush_e),
    .d(idex_d), .q(idex_q)
  );

  // ---------------- execute ----------------
  logic [XW-1:0] src_a, fwd_b_val, src_b, alu_y;
  logic [RW-1:0] wreg_e;

  always_comb begin
    unique case (fwd_a_e)
      2'b01:   src_a = result_w;
      2'b10:   src_a = exmem_q.alu;
      default: src_a = idex_q.rd1;
    endcase
    unique case (fwd_b_e)
      2'b01:   fwd_b_val = result_w;
      2'b10:   fwd_b_val = exmem_q.alu;
      default: fwd_b_val = idex_q.rd2;
    endcase
  end

  assign src_b  = idex_q.c.alu_src ? idex_q.simm : fwd_b_val;
  assign wreg_e = idex_q.c.reg_dst ? idex_q.rd : idex_q.rt;

  pipe5_alu #(.XW(XW)) u_alu (.op(idex_q.c.alu_op), .a(src_a), .b(src_b), .y(alu_y));

  assign hz_rs_e   = idex_q.rs;
  assign hz_rt_e   = idex_q.rt;
  assign hz_wreg_e = wreg_e;
  assign hz_regw_e = idex_q.c.reg_write;
  assign hz_load_e = idex_q.c.mem_to_reg;

  exmem_t exmem_d;
  assign exmem_d.regw = idex_q.c.reg_write;
  assign exmem_d.m2r  = idex_q.c.mem_to_reg;
  assign exmem_d.memw = idex_q.c.mem_write;
  assign exmem_d.alu  = alu_y;
  assign exmem_d.wd   = fwd_b_val;
  assign exmem_d.wreg = wreg_e;

  pipe5_stage_reg #(.W($bits(exmem_t))) u_exmem (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(1'b0),
    .d(exmem_d), .q(exmem_q)
  );

  // ---------------- memory ----------------
  assign dmem_addr  = exmem_q.alu;
  assign dmem_wdata = exmem_q.wd;
  assign dmem_we    = exmem_q.memw;
  assign hz_wreg_m  = exmem_q.wreg;
  assign hz_regw_m  = exmem_q.regw;
  assign hz_load_m  = exmem_q.m2r;

  memwb_t memwb_d;
  assign memwb_d.regw  = exmem_q.regw;
  assign memwb_d.m2r   = exmem_q.m2r;
  assign memwb_d.rdata = dmem_rdata;
  assign memwb_d.alu   = exmem_q.alu;
  assign memwb_d.wreg  = exmem_q.wreg;

  pipe5_stage_reg #(.W($bits(memwb_t))) u_memwb (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(1'b0),
    .d(memwb_d), .q(memwb_q)
  );

  // ---------------- writeback ----------------
  assign result_w  = memwb_q.m2r ? memwb_q.rdata : memwb_q.alu;
  assign hz_wreg_w = memwb_q.wreg;
  assign hz_regw_w = memwb_q.regw;
endmodule

// File: rtl/pipe5_core_checker.sv
module pipe5_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic        dmem_we,
  input logic        stall_f,
  input logic        stall_d,
  input logic        flush_d,
  input logic        flush_e,
  input logic        jump_d,
  input logic        taken_d,
  input logic [31:0] pc4_d,
  input logic [31:0] instr_d,
  input logic [31:0] simm_d,
  input logic [31:0] rd1_d,
  input logic        ex_regw,
  input logic        ex_memw
);
  // R1: reset state seen away from the clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (imem_addr == 32'd0 && !dmem_we);
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && !jump_d && !taken_d) |=> imem_addr == $past(imem_addr) + 32'd4);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_f |=> $stable(imem_addr));

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_d[25:21] == 5'd0) |-> rd1_d == 32'd0);

  p_branch_tgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_d && !jump_d && !stall_f) |=>
      imem_addr == $past(pc4_d) + {$past(simm_d[29:0]), 2'b00});

  p_jump_tgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_d && !stall_f) |=>
      imem_addr == {$past(pc4_d[31:28]), $past(instr_d[25:0]), 2'b00});

  p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_e |=> (!ex_regw && !ex_memw));

  p_hold_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_d && !flush_d) |=> $stable(instr_d));
endmodule

bind pipe5_core pipe5_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_we(dmem_we),
  .stall_f(stall_f), .stall_d(stall_d), .flush_d(flush_d), .flush_e(flush_e),
  .jump_d(jump_d), .taken_d(taken_d), .pc4_d(pc4_d), .instr_d(instr_d),
  .simm_d(simm_d), .rd1_d(rd1_d),
  .ex_regw(idex_q.c.reg_write), .ex_memw(idex_q.c.mem_write)
);

// File: tb/pipe5_hazard.sv
module pipe5_hazard (
  input  logic [4:0] rs_d,
  input  logic [4:0] rt_d,
  input  logic [4:0] rs_e,
  input  logic [4:0] rt_e,
  input  logic [4:0] wreg_e,
  input  logic [4:0] wreg_m,
  input  logic [4:0] wreg_w,
  input  logic       regw_e,
  input  logic       regw_m,
  input  logic       regw_w,
  input  logic       load_e,
  input  logic       load_m,
  input  logic       branch_d,
  input  logic       redirect_d,
  output logic       stall_f,
  output logic       stall_d,
  output logic       flush_d,
  output logic       flush_e,
  output logic       fwd_a_d,
  output logic       fwd_b_d,
  output logic [1:0] fwd_a_e,
  output logic [1:0] fwd_b_e
);
  logic load_hold, br_hold, hold;

  function automatic logic [1:0] pick(input logic [4:0] r, input logic [4:0] wm,
                                      input logic rm, input logic [4:0] ww, input logic rw);
    if (r != 5'd0 && rm && r == wm)      return 2'b10;
    else if (r != 5'd0 && rw && r == ww) return 2'b01;
    else                                  return 2'b00;
  endfunction

  always_comb begin
    fwd_a_e   = pick(rs_e, wreg_m, regw_m, wreg_w, regw_w);
    fwd_b_e   = pick(rt_e, wreg_m, regw_m, wreg_w, regw_w);
    fwd_a_d   = (rs_d != 5'd0) && regw_m && (rs_d == wreg_m);
    fwd_b_d   = (rt_d != 5'd0) && regw_m && (rt_d == wreg_m);
    load_hold = load_e && ((rt_e == rs_d) || (rt_e == rt_d));
    br_hold   = branch_d &&
                ((regw_e && wreg_e != 5'd0 && (wreg_e == rs_d || wreg_e == rt_d)) ||
                 (load_m && wreg_m != 5'd0 && (wreg_m == rs_d || wreg_m == rt_d)));
    hold      = load_hold || br_hold;
    stall_f   = hold;
    stall_d   = hold;
    flush_e   = hold;
    flush_d   = redirect_d && !hold;
  end
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [4:0]  rs_d, rt_d, rs_e, rt_e, wreg_e, wreg_m, wreg_w;
  logic        regw_e, regw_m, regw_w, load_e, load_m, branch_d, redirect_d;
  logic        stall_f, stall_d, flush_d, flush_e, fwd_a_d, fwd_b_d;
  logic [1:0]  fwd_a_e, fwd_b_e;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
    .hz_rs_d(rs_d), .hz_rt_d(rt_d), .hz_rs_e(rs_e), .hz_rt_e(rt_e),
    .hz_wreg_e(wreg_e), .hz_wreg_m(wreg_m), .hz_wreg_w(wreg_w),
    .hz_regw_e(regw_e), .hz_regw_m(regw_m), .hz_regw_w(regw_w),
    .hz_load_e(load_e), .hz_load_m(load_m), .hz_branch_d(branch_d), .redirect_d(redirect_d),
    .stall_f(stall_f), .stall_d(stall_d), .flush_d(flush_d), .flush_e(flush_e),
    .fwd_a_d(fwd_a_d), .fwd_b_d(fwd_b_d), .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e)
  );

  pipe5_hazard u_hz (
    .rs_d(rs_d), .rt_d(rt_d), .rs_e(rs_e), .rt_e(rt_e),
    .wreg_e(wreg_e), .wreg_m(wreg_m), .wreg_w(wreg_w),
    .regw_e(regw_e), .regw_m(regw_m), .regw_w(regw_w),
    .load_e(load_e), .load_m(load_m), .branch_d(branch_d), .redirect_d(redirect_d),
    .stall_f(stall_f), .stall_d(stall_d), .flush_d(flush_d), .flush_e(flush_e),
    .fwd_a_d(fwd_a_d), .fwd_b_d(fwd_b_d), .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e)
  );

  // ---------------- memories ----------------
  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  assign imem_rdata = prog[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [31:0] tgt);
    return {6'b000010, tgt[27:2]};
  endfunction

  localparam logic [5:0] ADDI = 6'b001000, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;
  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100,
                         F_OR = 6'b100101, F_SLT = 6'b101010;

  // ---------------- scoreboard ----------------
  int total = 0, bad = 0;
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  string       q_tag  [$];
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R11", "unexpected store addr", dmem_addr, 32'hffff_ffff);
      end else begin
        logic [31:0] ea, ed;
        string       et;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        et = q_tag.pop_front();
        check(dmem_addr == ea, et, "store address", dmem_addr, ea);
        check(dmem_wdata == ed, et, "store data", dmem_wdata, ed);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      check(1'b0, "R11", "watchdog expired, stores left", 32'(q_addr.size()), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = 32'd0; dmem[i] = 32'd0; end
    prog[0]  = enc_i(ADDI, 5'd8, 5'd0, 16'd9);          // $8 = 9
    prog[1]  = enc_i(ADDI, 5'd9, 5'd8, 16'hfffe);       // $9 = 7
    prog[2]  = enc_r(5'd10, 5'd8, 5'd9, F_SUB);         // $10 = 2
    prog[3]  = enc_r(5'd11, 5'd8, 5'd9, F_AND);         // $11 = 1
    prog[4]  = enc_r(5'd12, 5'd10, 5'd11, F_OR);        // $12 = 3
    prog[5]  = enc_r(5'd13, 5'd9, 5'd8, F_SLT);         // $13 = 1
    prog[6]  = enc_r(5'd14, 5'd12, 5'd13, F_ADD);       // $14 = 4
    prog[7]  = enc_i(BEQ, 5'd9, 5'd14, 16'd5);          // not taken
    prog[8]  = enc_i(SW, 5'd9, 5'd14, 16'd76);          // [80] = 7
    prog[9]  = enc_i(LW, 5'd15, 5'd0, 16'd80);          // $15 = 7
    prog[10] = enc_i(BEQ, 5'd9, 5'd15, 16'd1);          // taken to word 12
    prog[11] = enc_i(ADDI, 5'd15, 5'd0, 16'd1);         // must be skipped
    prog[12] = enc_r(5'd16, 5'd15, 5'd0, F_ADD);        // $16 = 7
    prog[13] = enc_j(32'h40);
    prog[14] = enc_i(SW, 5'd0, 5'd0, 16'd84);           // must be skipped
    prog[15] = enc_i(ADDI, 5'd16, 5'd0, 16'd0);         // must be skipped
    prog[16] = enc_i(SW, 5'd16, 5'd0, 16'd84);          // [84] = 7
    prog[17] = enc_i(SW, 5'd10, 5'd0, 16'd88);
    prog[18] = enc_i(SW, 5'd11, 5'd0, 16'd92);
    prog[19] = enc_i(SW, 5'd12, 5'd0, 16'd96);
    prog[20] = enc_i(SW, 5'd13, 5'd0, 16'd100);
    prog[21] = enc_r(5'd17, 5'd8, 5'd9, F_SLT);         // $17 = 0
    prog[22] = enc_i(SW, 5'd17, 5'd0, 16'd104);
    prog[23] = enc_i(ADDI, 5'd0, 5'd0, 16'd5);          // write to $0 discarded
    prog[24] = enc_i(SW, 5'd0, 5'd0, 16'd108);
    prog[25] = enc_i(SW, 5'd14, 5'd0, 16'd112);
    prog[26] = enc_j(32'h68);                           // park

    expect_store(32'd80,  32'd7, "R7/R10 not-taken beq after stall");
    expect_store(32'd84,  32'd7, "R5/R8/R9 taken beq and jump skip");
    expect_store(32'd88,  32'd2, "R6 sub with forwarding");
    expect_store(32'd92,  32'd1, "R3 and");
    expect_store(32'd96,  32'd3, "R6 or of forwarded results");
    expect_store(32'd100, 32'd1, "R3 slt true");
    expect_store(32'd104, 32'd0, "R3 slt false");
    expect_store(32'd108, 32'd0, "R4 zero register");
    expect_store(32'd112, 32'd4, "R6 add result");

    repeat (3) begin
      @(negedge clk);
      check(imem_addr == 32'd0, "R1", "pc in reset", imem_addr, 32'd0);
      check(!dmem_we, "R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
    end
    rst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(imem_addr == 32'(4 * k), "R2", "sequential fetch", imem_addr, 32'(4 * k));
    end

    for (int c = 0; c < 2000 && q_addr.size() != 0; c++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(q_addr.size() == 0, "R11", "stores outstanding", 32'(q_addr.size()), 32'd0);
    check(dmem[21] == 32'd7, "R11", "memory word at 84", dmem[21], 32'd7);
    check(dmem[20] == 32'd7, "R3", "memory word at 80 after lw path", dmem[20], 32'd7);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule